// File: doc/BRIEF.md
# Microsequenced Accumulator Processor

This block is a small processor built around one 16-bit accumulator. It fetches 16-bit instruction words from an internal word memory. The memory has 2^ADDR_W words of 16 bits, and a side port can load it while the core is held in reset. Every instruction runs as a fixed five-step fetch and then a short run of execute steps. Each step is one clock and performs one register transfer. Carry from an addition goes into a separate one-bit carry register.

The core has five operations: add a memory word to the accumulator, store the accumulator, read a console word into the accumulator, write the accumulator to the console, and halt. All other operation codes do nothing and return straight to fetch. Console traffic uses valid/ready handshakes, and the core waits in the matching step until its partner agrees. A halted flag, the carry bit and the current step code are visible at the ports, so the cycle cost of every instruction can be observed from outside.

States and their codes on `state_dbg`:
- Fetch: FETCH_AR (0) → FETCH_IR (1) → FETCH_PC (2) → FETCH_ADDR (3) → DECODE (4).
- Leaving DECODE:
  - ADD_RD (5) → ADD_SUM (6) → FETCH_AR.
  - STORE (7) → FETCH_AR.
  - INPUT (8) loops on itself until `in_valid`, then goes to FETCH_AR.
  - OUTPUT (9) loops on itself until `out_ready`, then goes to FETCH_AR.
  - HALT_SET (10) → HALTED (11), and HALTED loops on itself forever.
  - Any other operation code goes from DECODE straight back to FETCH_AR.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `state_dbg` is 0, `halted`, `carry`, `in_ready` and `out_valid` are 0, and all internal registers are zero, so execution begins at word 0.
- R2: An instruction word carries its operation code in bits 15:12 and its address in bits 11:0. The program counter advances by one in every fetch and wraps from the top word to word 0.
- R3: Every instruction begins with fetch steps 0, 1, 2, 3, 4 on successive clocks, and only the state transitions listed above ever occur.
- R4: Code 4 (add) takes steps 5 then 6. It adds the addressed word to the accumulator modulo 2^16 and puts the carry-out on `carry`.
- R5: Code 3 (store) takes one step, 7, and writes the accumulator into the addressed word.
- R6: Code 1 (output) holds `out_valid` high with the accumulator on `out_data`, unchanged, until a clock on which `out_ready` is high. Step 9 ends on that clock.
- R7: Code 0 (input) raises `in_ready` in step 8 and waits there. On the clock where `in_valid` is high, it loads `in_data` into the accumulator and ends.
- R8: `in_valid` has no effect outside step 8, and `out_ready` has no effect outside step 9. `in_ready` and `out_valid` are never high together.
- R9: Code 2 (halt) takes step 10 and then parks in step 11 with `halted` high. No fetch ever follows.
- R10: Codes 5 to 15 leave DECODE directly for step 0 and change no register.
- R11: When `load_en` is high, `load_data` is written into word `load_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Memory load strobe |
| load_addr | input | ADDR_W | Memory load address |
| load_data | input | 16 | Memory load word |
| in_valid | input | 1 | Console input word offered |
| in_data | input | 16 | Console input word |
| in_ready | output | 1 | Core is waiting for an input word |
| out_valid | output | 1 | Console output word offered |
| out_ready | input | 1 | Console accepts the output word |
| out_data | output | 16 | Console output word (accumulator) |
| halted | output | 1 | Halt bit |
| carry | output | 1 | Carry register |
| state_dbg | output | 4 | Current step code |

## Verification
Two things can arrive in the same cycle: an input word offered while the core is stalled in an output step, and a ready pulse while it waits in an input step. The bench holds `in_valid` high with a marker word through several add, store and output instructions. Every output must then show the computed sum and never the marker. Meanwhile `out_ready` toggles freely through the input stalls, and no extra output may appear.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [3:0] {
        S_FETCH_AR   = 4'd0,
        S_FETCH_IR   = 4'd1,
        S_FETCH_PC   = 4'd2,
        S_FETCH_ADDR = 4'd3,
        S_DECODE     = 4'd4,
        S_ADD_RD     = 4'd5,
        S_ADD_SUM    = 4'd6,
        S_STORE      = 4'd7,
        S_INPUT      = 4'd8,
        S_OUTPUT     = 4'd9,
        S_HALT_SET   = 4'd10,
        S_HALTED     = 4'd11
    } ctl_state_e;

    localparam logic [OP_W-1:0] OP_INP = 4'd0;
    localparam logic [OP_W-1:0] OP_OUT = 4'd1;
    localparam logic [OP_W-1:0] OP_HLT = 4'd2;
    localparam logic [OP_W-1:0] OP_STA = 4'd3;
    localparam logic [OP_W-1:0] OP_ADD = 4'd4;

endpackage

// File: rtl/acc_word_ram.sv
module acc_word_ram #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Read is combinational so a transfer into IR or DR completes in one step.
    assign rdata = words[raddr];

endmodule

// File: rtl/acc_carry_add.sv
module acc_carry_add #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          cout
);
    logic [DW:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        sum  = wide[DW-1:0];
        cout = wide[DW];
    end

endmodule

// File: rtl/acc_cpu_ctl.sv
module acc_cpu_ctl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            in_valid,
    input  logic            out_ready,
    output ctl_state_e      state_o
);
    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH_AR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH_AR:   state_d = S_FETCH_IR;
            S_FETCH_IR:   state_d = S_FETCH_PC;
            S_FETCH_PC:   state_d = S_FETCH_ADDR;
            S_FETCH_ADDR: state_d = S_DECODE;
            S_DECODE: begin
                case (opcode)
                    OP_INP:  state_d = S_INPUT;
                    OP_OUT:  state_d = S_OUTPUT;
                    OP_HLT:  state_d = S_HALT_SET;
                    OP_STA:  state_d = S_STORE;
                    OP_ADD:  state_d = S_ADD_RD;
                    default: state_d = S_FETCH_AR;
                endcase
            end
            S_ADD_RD:   state_d = S_ADD_SUM;
            S_ADD_SUM:  state_d = S_FETCH_AR;
            S_STORE:    state_d = S_FETCH_AR;
            S_INPUT:    state_d = in_valid  ? S_FETCH_AR : S_INPUT;
            S_OUTPUT:   state_d = out_ready ? S_FETCH_AR : S_OUTPUT;
            S_HALT_SET: state_d = S_HALTED;
            S_HALTED:   state_d = S_HALTED;
            default:    state_d = S_FETCH_AR;
        endcase
    end

    assign state_o = state_q;

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FETCH_AR |=> state_q == S_FETCH_IR); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HALTED |=> state_q == S_HALTED); // R9
    AST_OUT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OUTPUT && !out_ready) |=> state_q == S_OUTPUT); // R6
    AST_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INPUT && !in_valid) |=> state_q == S_INPUT); // R7

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [ADDR_W-1:0]        load_addr,
    input  logic [OP_W+ADDR_W-1:0]   load_data,
    input  logic                     in_valid,
    input  logic [OP_W+ADDR_W-1:0]   in_data,
    output logic                     in_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [OP_W+ADDR_W-1:0]   out_data,
    output logic                     halted,
    output logic                     carry,
    output logic [3:0]               state_dbg
);
    localparam int DATA_W = OP_W + ADDR_W;

    logic [DATA_W-1:0] ac, dr, ir;
    logic [ADDR_W-1:0] ar, pc;
    logic              e_bit, halt_bit;

    ctl_state_e        state;
    logic [DATA_W-1:0] mem_rd, sum;
    logic              sum_cout;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    acc_cpu_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (ir[DATA_W-1 -: OP_W]),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .state_o   (state)
    );

    acc_word_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ar),
        .rdata (mem_rd)
    );

    acc_carry_add #(.DW(DATA_W)) u_add (
        .a    (ac),
        .b    (dr),
        .sum  (sum),
        .cout (sum_cout)
    );

    // Loader has priority; it is used while the core sits in reset.
    always_comb begin
        mem_we    = load_en || (state == S_STORE);
        mem_waddr = load_en ? load_addr : ar;
        mem_wdata = load_en ? load_data : ac;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac       <= '0;
            dr       <= '0;
            ir       <= '0;
            ar       <= '0;
            pc       <= '0;
            e_bit    <= 1'b0;
            halt_bit <= 1'b0;
        end else begin
            unique case (state)
                S_FETCH_AR:   ar <= pc;
                S_FETCH_IR:   ir <= mem_rd;
                S_FETCH_PC:   pc <= pc + 1'b1;
                S_FETCH_ADDR: ar <= ir[ADDR_W-1:0];
                S_ADD_RD:     dr <= mem_rd;
                S_ADD_SUM: begin
                    ac    <= sum;
                    e_bit <= sum_cout;
                end
                S_INPUT: begin
                    if (in_valid) begin
                        ac <= in_data;
                    end
                end
                S_HALT_SET:   halt_bit <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready  = (state == S_INPUT);
        out_valid = (state == S_OUTPUT);
        out_data  = ac;
        halted    = halt_bit;
        carry     = e_bit;
        state_dbg = state;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH_PC |=> pc == $past(pc) + 1'b1); // R2
    AST_HALT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        halt_bit |-> state == S_HALTED); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ready, out_valid})); // R8
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R6

endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

    localparam int AW = 12;

    typedef struct {
        logic [15:0] data;
        logic        cy;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0]   load_data = '0;
    logic          in_valid = 1'b0;
    logic [15:0]   in_data = '0;
    logic          in_ready, out_valid, halted, carry;
    logic          out_ready = 1'b0;
    logic [15:0]   out_data;
    logic [3:0]    state_dbg;

    int checks = 0, errors = 0;
    int cyc = 0, out_count = 0, nop_seen = 0, bad_trans = 0;
    int fetch_after_halt = 0, drop_cnt = 0, clash_cnt = 0;
    bit seen_halt = 0, have_prev = 0, prev_ov = 0, prev_hs = 0;
    logic [3:0] prev_st = '0;
    exp_t q[$];

    always #5 clk = ~clk;

    acc_cpu_core #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .halted(halted), .carry(carry), .state_dbg(state_dbg)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit legal(input logic [3:0] p, input logic [3:0] n);
        case (p)
            4'd0: return n == 4'd1;
            4'd1: return n == 4'd2;
            4'd2: return n == 4'd3;
            4'd3: return n == 4'd4;
            4'd4: return n inside {4'd0, 4'd5, 4'd7, 4'd8, 4'd9, 4'd10};
            4'd5: return n == 4'd6;
            4'd6, 4'd7: return n == 4'd0;
            4'd8: return n inside {4'd8, 4'd0};
            4'd9: return n inside {4'd9, 4'd0};
            4'd10, 4'd11: return n == 4'd11;
            default: return 1'b0;
        endcase
    endfunction

    // Monitor: transition legality, output scoreboard, drives out_ready.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_prev = 0; prev_ov = 0; prev_hs = 0; seen_halt = 0;
            out_ready = 1'b0;
        end else begin
            bit hs;
            cyc++;
            if (have_prev) begin
                if (!legal(prev_st, state_dbg)) begin
                    bad_trans++;
                    $display("illegal step %0d -> %0d", prev_st, state_dbg);
                end
                if (prev_st == 4'd4 && state_dbg == 4'd0) nop_seen++;
                if (seen_halt && state_dbg == 4'd0) fetch_after_halt++;
            end
            if (halted) seen_halt = 1;
            if (prev_ov && !prev_hs && !out_valid) drop_cnt++;
            if (in_ready && out_valid) clash_cnt++;
            out_ready = (cyc % 4 == 3);
            hs = out_valid && out_ready;
            if (hs) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected output", {16'd0, out_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_data == e.data, e.tag, {16'd0, out_data}, {16'd0, e.data});
                    chk(carry == e.cy, {e.tag, " carry R4"}, {31'd0, carry}, {31'd0, e.cy});
                end
                out_count++;
            end
            prev_st = state_dbg; have_prev = 1; prev_ov = out_valid; prev_hs = hs;
        end
    end

    task automatic load_word(input int a, input logic [15:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = AW'(a); load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic give_input(input logic [15:0] d, input int delay);
        while (!in_ready) @(negedge clk);
        repeat (delay) @(negedge clk);
        if (delay > 0) chk(state_dbg == 4'd8 && in_ready, "R7 stall", {28'd0, state_dbg}, 32'd8);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] d, input logic c, input string t);
        exp_t e;
        e.data = d; e.cy = c; e.tag = t;
        q.push_back(e);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                chk(1'b0, "watchdog", wd, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // Program one: R11 loader fills code and data.
        load_word(0, 16'h0000);  load_word(1, 16'h4100);  load_word(2, 16'h1000);
        load_word(3, 16'h3101);  load_word(4, 16'h4101);  load_word(5, 16'h1000);
        load_word(6, 16'h4102);  load_word(7, 16'h1000);  load_word(8, 16'h5000);
        load_word(9, 16'hF123);  load_word(10, 16'h4103); load_word(11, 16'h1000);
        load_word(12, 16'h0000); load_word(13, 16'h1000); load_word(14, 16'h2000);
        load_word(12'h100, 16'h0001); load_word(12'h101, 16'h0000);
        load_word(12'h102, 16'hFFFF); load_word(12'h103, 16'h0000);

        @(negedge clk);
        chk(state_dbg == 4'd0 && !halted && !carry && !in_ready && !out_valid,
            "R1 reset", {28'd0, state_dbg}, 32'd0);

        push(16'h1235, 1'b0, "R11 loaded program add");
        push(16'h246A, 1'b0, "R5 stored word re-added");
        push(16'h2469, 1'b1, "R4 sum with carry out");
        push(16'h2469, 1'b0, "R8 input offered during output");
        push(16'h0007, 1'b0, "R7 input after stall");

        rst_n = 1'b1;
        chk(state_dbg == 4'd0 && !out_valid, "R1 first cycle", {28'd0, state_dbg}, 32'd0);
        for (int s = 1; s <= 4; s++) begin
            @(negedge clk);
            chk(state_dbg == 4'(s), "R3 fetch order", {28'd0, state_dbg}, s);
        end
        @(negedge clk);
        chk(state_dbg == 4'd8 && in_ready, "R7 waits for input", {28'd0, state_dbg}, 32'd8);

        give_input(16'h1234, 2);
        // R8: marker word offered while no input step is active.
        in_valid = 1'b1; in_data = 16'hBEEF;
        wait (out_count == 4);
        @(negedge clk);
        in_valid = 1'b0;
        give_input(16'h0007, 3);

        wait (halted);
        repeat (20) @(negedge clk);
        chk(state_dbg == 4'd11 && halted, "R9 parked", {28'd0, state_dbg}, 32'd11);
        chk(fetch_after_halt == 0, "R9 no fetch", fetch_after_halt, 0);
        chk(nop_seen == 2, "R10 no-op count", nop_seen, 2);
        chk(out_count == 5 && q.size() == 0, "R6 output count", out_count, 5);

        // Program two: R2 counter wrap through a memory full of no-ops.
        rst_n = 1'b0;
        for (int a = 0; a < (1 << AW); a++) begin
            logic [15:0] w;
            w = (a == 0) ? 16'h0000 : (a == 1) ? 16'h1000 : 16'h5000;
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(a); load_data = w;
        end
        @(negedge clk);
        load_en = 1'b0;
        push(16'h00AA, 1'b0, "R2 first pass");
        push(16'h0055, 1'b0, "R2 after wrap");
        rst_n = 1'b1;
        give_input(16'h00AA, 0);
        give_input(16'h0055, 1);
        wait (out_count == 7);
        @(negedge clk);
        chk(q.size() == 0, "R2 wrap reached word 0", q.size(), 0);

        chk(bad_trans == 0, "R3 transitions", bad_trans, 0);
        chk(drop_cnt == 0, "R6 valid held", drop_cnt, 0);
        chk(clash_cnt == 0, "R8 strobes exclusive", clash_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule